// File: doc/BRIEF.md
# Relocatable Instruction Cache with Line Fill

This block sits between an instruction fetch unit and a banked backing memory. It keeps a 512-byte window of code in 32 lines of 16 bytes. The window starts at a movable 16-bit cache base. Every opcode fetch is classed as a hit, a miss or an uncached fetch. A hit is served from the cache. A miss first copies the whole 16-byte line from memory, one byte at a time, and then returns the requested byte. An uncached fetch reads a single byte straight from memory. Each outcome takes a fixed number of cycles, and that number depends on whether the fast clock mode is selected.

A flush input clears every line's valid bit. A host port can read and write the cache storage directly, with addresses taken relative to the base. A host write to the last byte of a line marks that line valid. This lets software preload code without any memory traffic. Only one fetch is in flight at a time: the requester holds `fetch_req` and its address until `fetch_done` pulses.

Top module: `reloc_icache`

## Requirements
- R1: The fetch offset is `fetch_pc - cache_base` taken modulo 2^16. The fetch is cached only when the offset is below 512. Offset bits [8:4] select the line and bits [3:0] select the byte within it.
- R2: On a cached fetch whose line is valid, `fetch_done` pulses 1 cycle after acceptance in fast mode and 2 cycles after in slow mode. `fetch_data` carries the stored byte, and no memory access is made.
- R3: On a cached fetch whose line is invalid, 16 memory reads are made in ascending order. Read i uses address `{prog_bank, ((cache_base + (offset & 0xFFF0)) & 0xFFF0) + i}`. Reads are spaced 5 cycles apart in fast mode and 6 cycles apart in slow mode, and each read occurs in the last cycle of its slot. `fetch_done` pulses 16 slots after acceptance, the line then becomes valid, and the bytes are stored.
- R4: On an uncached fetch, one memory read is made at `{prog_bank, fetch_pc}`. `fetch_done` pulses 5 (fast) or 6 (slow) cycles after acceptance, carrying the byte that was read.
- R5: `mem_ram` is 1 during a memory read when the bank is above 0x5F, and 0 when the bank is 0x5F or below.
- R6: A flush clears all 32 valid bits, so later fetches to those lines miss. No fetch is accepted in a cycle where flush is high.
- R7: A flush during a line fill aborts the fill. There is no `fetch_done`, no further reads are made and the line stays invalid. A request that is still held then starts a fresh fill.
- R8: A host read uses index `(host_addr + cache_base) & 511`. `host_rdata` shows the stored byte in the cycle after `host_rd`, and holds its value when no host read is made.
- R9: A host write stores a byte at the same index. If the low four bits of the index are all ones, that line becomes valid. Writes to other bytes leave the line's valid bit unchanged. In the same cycle, a fill write to the same index overrides the host write, and a flush overrides any validation.
- R10: After reset, `fetch_done`, `mem_req`, `fetch_data` and `host_rdata` are 0. `fetch_done` is a one-cycle pulse, and `fetch_data` holds its value until the next pulse.
- R11: The clock mode is sampled when a fetch is accepted, and it fixes all costs for that fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_base | input | 16 | Start address of the cached window |
| prog_bank | input | 8 | Bank of the fetch, upper address byte |
| fast_mode | input | 1 | 1 selects the fast clock costs |
| flush | input | 1 | Invalidate all lines; aborts a fill |
| fetch_req | input | 1 | Fetch request, held until fetch_done |
| fetch_pc | input | 16 | Fetch address within the bank |
| fetch_done | output | 1 | One-cycle completion pulse |
| fetch_data | output | 8 | Fetched byte |
| mem_req | output | 1 | Memory read strobe, data taken this cycle |
| mem_addr | output | 24 | Memory read address {bank, address} |
| mem_ram | output | 1 | 1 selects RAM, 0 selects ROM |
| mem_rdata | input | 8 | Memory read data, valid while mem_req |
| host_rd | input | 1 | Host read of cache storage |
| host_wr | input | 1 | Host write of cache storage |
| host_addr | input | 16 | Host address, relative to cache_base |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle later |

## Verification
Fetches are made just inside and just outside both ends of the window, including a negative offset and offset 512. These show whether the window check uses the 16-bit wrapped difference. Fills are run with the base moved near the top of the address space, so the source address must wrap. Hits and misses are run in both clock modes and in both ROM and RAM banks, which separates the cost selection from the memory-space selection. Flushes are given while idle, during a request and in the middle of a fill. Host writes are given on full lines, on partial lines and during a fill, which shows whether line validation depends only on the final byte and how it ranks against flush and fill.

// File: rtl/reloc_icache_pkg.sv
package reloc_icache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HIT    = 2'd1,
        ST_FILL   = 2'd2,
        ST_DIRECT = 2'd3
    } fetch_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ric_lookup.sv
module ric_lookup #(
    parameter int AW      = 16,
    parameter int CACHE_B = 512,
    parameter int LINE_B  = 16,
    localparam int IDX_W  = $clog2(CACHE_B),
    localparam int OFF_W  = $clog2(LINE_B),
    localparam int LINES  = CACHE_B / LINE_B,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic [AW-1:0]     pc,
    input  logic [AW-1:0]     base,
    input  logic [LINES-1:0]  valid,
    output logic              cached,
    output logic              hit,
    output logic [LINE_W-1:0] line,
    output logic [OFF_W-1:0]  nib,
    output logic [AW-1:0]     fill_addr
);
    localparam logic [AW-1:0] LMASK = ~AW'(LINE_B - 1);

    logic [AW-1:0] off;

    always_comb begin
        off       = pc - base;
        cached    = (off[AW-1:IDX_W] == '0);
        line      = off[IDX_W-1:OFF_W];
        nib       = off[OFF_W-1:0];
        hit       = cached && valid[line];
        fill_addr = (base + (off & LMASK)) & LMASK;
    end
endmodule

// File: rtl/ric_store.sv
module ric_store #(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int CACHE_B = 512,
    parameter int LINE_B  = 16,
    localparam int IDX_W  = $clog2(CACHE_B),
    localparam int OFF_W  = $clog2(LINE_B),
    localparam int LINES  = CACHE_B / LINE_B,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     base,
    input  logic              flush,
    input  logic              fill_we,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [DW-1:0]     fill_data,
    input  logic              fill_set,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [AW-1:0]     host_addr,
    input  logic [DW-1:0]     host_wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DW-1:0]     rd_data,
    output logic [LINES-1:0]  valid,
    output logic [DW-1:0]     host_rdata
);
    logic [DW-1:0]    arr_q [CACHE_B];
    logic [DW-1:0]    arr_d [CACHE_B];
    logic [LINES-1:0] valid_q, valid_d;
    logic [DW-1:0]    hrd_q, hrd_d;

    logic [AW-1:0]     h_sum;
    logic [IDX_W-1:0]  h_idx;
    logic [LINE_W-1:0] h_line;
    logic              h_closes;

    always_comb begin
        h_sum    = host_addr + base;
        h_idx    = IDX_W'(h_sum & AW'(CACHE_B - 1));
        h_line   = h_idx[IDX_W-1:OFF_W];
        h_closes = host_wr && (&h_idx[OFF_W-1:0]);
    end

    // storage: host write first, a same-index fill write overrides it
    always_comb begin
        arr_d = arr_q;
        hrd_d = hrd_q;
        if (host_rd) hrd_d = arr_q[h_idx];
        if (host_wr) arr_d[h_idx] = host_wdata;
        if (fill_we) arr_d[fill_idx] = fill_data;
    end

    // one valid bit per line; flush has the last word
    for (genvar g = 0; g < LINES; g++) begin : g_valid
        assign valid_d[g] = !flush &&
                            (valid_q[g] ||
                             (fill_set && (fill_line == LINE_W'(g))) ||
                             (h_closes && (h_line == LINE_W'(g))));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_q   <= '{default: '0};
            valid_q <= '0;
            hrd_q   <= '0;
        end else begin
            arr_q   <= arr_d;
            valid_q <= valid_d;
            hrd_q   <= hrd_d;
        end
    end

    assign rd_data    = arr_q[rd_idx];
    assign valid      = valid_q;
    assign host_rdata = hrd_q;
endmodule

// File: rtl/ric_ctrl.sv
module ric_ctrl
    import reloc_icache_pkg::*;
#(
    parameter int AW        = 16,
    parameter int BW        = 8,
    parameter int DW        = 8,
    parameter int CACHE_B   = 512,
    parameter int LINE_B    = 16,
    parameter int FAST_COST = 5,
    parameter int SLOW_COST = 6,
    parameter int FAST_HIT  = 1,
    parameter int SLOW_HIT  = 2,
    parameter logic [BW-1:0] ROM_LAST = 8'h5F,
    localparam int IDX_W  = $clog2(CACHE_B),
    localparam int OFF_W  = $clog2(LINE_B),
    localparam int LINES  = CACHE_B / LINE_B,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_mode,
    input  logic              flush,
    input  logic              fetch_req,
    input  logic [AW-1:0]     fetch_pc,
    input  logic [BW-1:0]     prog_bank,
    input  logic              lk_cached,
    input  logic              lk_hit,
    input  logic [LINE_W-1:0] lk_line,
    input  logic [OFF_W-1:0]  lk_nib,
    input  logic [AW-1:0]     lk_fill_addr,
    output logic              fetch_done,
    output logic [DW-1:0]     fetch_data,
    output logic              mem_req,
    output logic [BW+AW-1:0]  mem_addr,
    output logic              mem_ram,
    input  logic [DW-1:0]     mem_rdata,
    output logic              fill_we,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [DW-1:0]     fill_data,
    output logic              fill_set,
    output logic [LINE_W-1:0] fill_line,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [DW-1:0]     rd_data
);
    localparam int CNT_W = $clog2(imax(imax(FAST_COST, SLOW_COST),
                                       imax(FAST_HIT, SLOW_HIT)) + 1);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_FAST  = CNT_W'(FAST_COST);
    localparam logic [CNT_W-1:0] C_SLOW  = CNT_W'(SLOW_COST);
    localparam logic [CNT_W-1:0] H_FAST1 = CNT_W'(FAST_HIT - 1);
    localparam logic [CNT_W-1:0] H_SLOW1 = CNT_W'(SLOW_HIT - 1);
    localparam logic [OFF_W-1:0] LAST    = OFF_W'(LINE_B - 1);

    typedef struct packed {
        fetch_state_e      st;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  cost;
        logic [OFF_W-1:0]  beat;
        logic [OFF_W-1:0]  nib;
        logic [LINE_W-1:0] line;
        logic [AW-1:0]     addr;
        logic [BW-1:0]     bank;
        logic [DW-1:0]     grab;
        logic              done;
        logic [DW-1:0]     data;
    } ctrl_t;

    ctrl_t q, n;
    logic  slot_end;

    always_comb begin
        slot_end = ((q.st == ST_FILL) || (q.st == ST_DIRECT)) && (q.cnt == '0);
        n        = q;
        n.done   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (fetch_req && !flush) begin
                    n.cost = fast_mode ? C_FAST : C_SLOW;
                    n.bank = prog_bank;
                    n.line = lk_line;
                    n.nib  = lk_nib;
                    n.beat = '0;
                    if (!lk_cached) begin
                        n.st   = ST_DIRECT;
                        n.addr = fetch_pc;
                        n.cnt  = n.cost - ONE;
                    end else if (lk_hit) begin
                        n.st  = ST_HIT;
                        n.cnt = fast_mode ? H_FAST1 : H_SLOW1;
                    end else begin
                        n.st   = ST_FILL;
                        n.addr = lk_fill_addr;
                        n.cnt  = n.cost - ONE;
                    end
                end
            end
            ST_HIT: begin
                if (q.cnt == '0) begin
                    n.st   = ST_IDLE;
                    n.done = 1'b1;
                    n.data = rd_data;
                end else begin
                    n.cnt = q.cnt - ONE;
                end
            end
            ST_FILL: begin
                if (flush) begin
                    n.st = ST_IDLE;
                end else if (q.cnt == '0) begin
                    if (q.beat == q.nib) n.grab = mem_rdata;
                    if (q.beat == LAST) begin
                        n.st   = ST_IDLE;
                        n.done = 1'b1;
                        n.data = (q.nib == LAST) ? mem_rdata : q.grab;
                    end else begin
                        n.beat = q.beat + OFF_W'(1);
                        n.cnt  = q.cost - ONE;
                    end
                end else begin
                    n.cnt = q.cnt - ONE;
                end
            end
            ST_DIRECT: begin
                if (q.cnt == '0) begin
                    n.st   = ST_IDLE;
                    n.done = 1'b1;
                    n.data = mem_rdata;
                end else begin
                    n.cnt = q.cnt - ONE;
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        mem_req    = slot_end;
        mem_addr   = {q.bank, (q.st == ST_FILL) ? (q.addr | AW'(q.beat)) : q.addr};
        mem_ram    = (q.bank > ROM_LAST);
        fill_we    = (q.st == ST_FILL) && (q.cnt == '0) && !flush;
        fill_idx   = {q.line, q.beat};
        fill_data  = mem_rdata;
        fill_set   = fill_we && (q.beat == LAST);
        fill_line  = q.line;
        rd_idx     = {q.line, q.nib};
        fetch_done = q.done;
        fetch_data = q.data;
    end
endmodule

// File: rtl/reloc_icache.sv
module reloc_icache #(
    parameter int AW        = 16,
    parameter int BW        = 8,
    parameter int DW        = 8,
    parameter int CACHE_B   = 512,
    parameter int LINE_B    = 16,
    parameter int FAST_COST = 5,
    parameter int SLOW_COST = 6,
    parameter int FAST_HIT  = 1,
    parameter int SLOW_HIT  = 2,
    parameter logic [BW-1:0] ROM_LAST = 8'h5F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    cache_base,
    input  logic [BW-1:0]    prog_bank,
    input  logic             fast_mode,
    input  logic             flush,
    input  logic             fetch_req,
    input  logic [AW-1:0]    fetch_pc,
    output logic             fetch_done,
    output logic [DW-1:0]    fetch_data,
    output logic             mem_req,
    output logic [BW+AW-1:0] mem_addr,
    output logic             mem_ram,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             host_rd,
    input  logic             host_wr,
    input  logic [AW-1:0]    host_addr,
    input  logic [DW-1:0]    host_wdata,
    output logic [DW-1:0]    host_rdata
);
    localparam int IDX_W  = $clog2(CACHE_B);
    localparam int OFF_W  = $clog2(LINE_B);
    localparam int LINES  = CACHE_B / LINE_B;
    localparam int LINE_W = $clog2(LINES);

    logic              lk_cached, lk_hit;
    logic [LINE_W-1:0] lk_line;
    logic [OFF_W-1:0]  lk_nib;
    logic [AW-1:0]     lk_fill_addr;
    logic [LINES-1:0]  valid;
    logic              fill_we, fill_set;
    logic [IDX_W-1:0]  fill_idx, rd_idx;
    logic [DW-1:0]     fill_data, rd_data;
    logic [LINE_W-1:0] fill_line;

    ric_lookup #(.AW(AW), .CACHE_B(CACHE_B), .LINE_B(LINE_B)) u_lookup (
        .pc(fetch_pc), .base(cache_base), .valid(valid),
        .cached(lk_cached), .hit(lk_hit), .line(lk_line), .nib(lk_nib),
        .fill_addr(lk_fill_addr)
    );

    ric_ctrl #(
        .AW(AW), .BW(BW), .DW(DW), .CACHE_B(CACHE_B), .LINE_B(LINE_B),
        .FAST_COST(FAST_COST), .SLOW_COST(SLOW_COST),
        .FAST_HIT(FAST_HIT), .SLOW_HIT(SLOW_HIT), .ROM_LAST(ROM_LAST)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .flush(flush),
        .fetch_req(fetch_req), .fetch_pc(fetch_pc), .prog_bank(prog_bank),
        .lk_cached(lk_cached), .lk_hit(lk_hit), .lk_line(lk_line),
        .lk_nib(lk_nib), .lk_fill_addr(lk_fill_addr),
        .fetch_done(fetch_done), .fetch_data(fetch_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ram(mem_ram),
        .mem_rdata(mem_rdata),
        .fill_we(fill_we), .fill_idx(fill_idx), .fill_data(fill_data),
        .fill_set(fill_set), .fill_line(fill_line),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    ric_store #(.AW(AW), .DW(DW), .CACHE_B(CACHE_B), .LINE_B(LINE_B)) u_store (
        .clk(clk), .rst_n(rst_n), .base(cache_base), .flush(flush),
        .fill_we(fill_we), .fill_idx(fill_idx), .fill_data(fill_data),
        .fill_set(fill_set), .fill_line(fill_line),
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .rd_idx(rd_idx), .rd_data(rd_data),
        .valid(valid), .host_rdata(host_rdata)
    );
endmodule

// File: rtl/reloc_icache_chk.sv
module reloc_icache_chk #(
    parameter int BW = 8,
    parameter int DW = 8,
    parameter logic [BW-1:0] ROM_LAST = 8'h5F
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_req,
    input logic          fetch_done,
    input logic          mem_req,
    input logic          mem_ram,
    input logic [BW-1:0] prog_bank,
    input logic          host_rd,
    input logic [DW-1:0] host_rdata
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> !fetch_done);

    // R10
    req_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> fetch_req);

    // R3
    read_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (!$past(mem_req, 1) && !$past(mem_req, 2) &&
                     !$past(mem_req, 3) && !$past(mem_req, 4)));

    // R5
    space_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_ram == (prog_bank > ROM_LAST)));

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));
endmodule

bind reloc_icache reloc_icache_chk #(.BW(BW), .DW(DW), .ROM_LAST(ROM_LAST)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_done(fetch_done),
    .mem_req(mem_req), .mem_ram(mem_ram), .prog_bank(prog_bank),
    .host_rd(host_rd), .host_rdata(host_rdata)
);

// File: tb/reloc_icache_test.sv
`timescale 1ns/1ps
module reloc_icache_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cache_base;
    logic [7:0]  prog_bank;
    logic        fast_mode, flush, fetch_req;
    logic [15:0] fetch_pc;
    logic        fetch_done;
    logic [7:0]  fetch_data;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic        mem_ram;
    logic [7:0]  mem_rdata;
    logic        host_rd, host_wr;
    logic [15:0] host_addr;
    logic [7:0]  host_wdata, host_rdata;

    always #10 clk = ~clk;

    reloc_icache uut (.*);

    function automatic logic [7:0] memfn(input logic [23:0] a, input logic ram);
        return ram ? (a[7:0] ^ a[15:8] ^ 8'h5A) : (a[7:0] + a[15:8] + a[23:16] + 8'h11);
    endfunction
    assign mem_rdata = memfn(mem_addr, mem_ram);

    int    vectors = 0;
    int    miscompares = 0;
    string tag = "R10 reset";

    // reference model state
    logic [7:0]  mcache [512];
    bit          mvalid [32];
    bit          m_busy;
    int          m_kind, m_el, m_total, m_c, m_line, m_nib;
    logic [15:0] m_lbase, m_pc;
    logic [7:0]  m_bank, m_grab;
    logic        e_done, e_req, e_ram;
    logic [7:0]  e_data, e_hrd;
    logic [23:0] e_addr;

    always @(posedge clk) begin : model
        bit          was_busy, fill_wr, set_v;
        int          fill_i, done_line, hidx, off;
        logic [7:0]  fbyte, nxt_hrd;
        logic [15:0] diff;
        if (!rst_n) begin
            foreach (mcache[i]) mcache[i] = 8'h00;
            foreach (mvalid[i]) mvalid[i] = 1'b0;
            m_busy = 0; m_c = 6; m_el = 0; m_total = 0; m_kind = 0;
            e_done = 0; e_req = 0; e_ram = 0; e_data = 0; e_hrd = 0; e_addr = 0;
        end else begin
            was_busy = m_busy; fill_wr = 0; set_v = 0; fill_i = 0; done_line = 0;
            fbyte = 0;
            hidx = int'((host_addr + cache_base) & 16'h01FF);
            nxt_hrd = host_rd ? mcache[hidx] : e_hrd;
            e_done = 0;
            if (m_busy) begin
                if (m_kind == 1 && flush) m_busy = 0;
                else begin
                    if (e_req) begin
                        fbyte = memfn(e_addr, e_ram);
                        if (m_kind == 1) begin
                            fill_wr = 1;
                            fill_i = m_line * 16 + m_el / m_c;
                            if (m_el / m_c == m_nib) m_grab = fbyte;
                        end else m_grab = fbyte;
                    end
                    m_el++;
                    if (m_el == m_total) begin
                        e_done = 1; m_busy = 0;
                        e_data = (m_kind == 0) ? mcache[m_line * 16 + m_nib] : m_grab;
                        if (m_kind == 1) begin set_v = 1; done_line = m_line; end
                    end
                end
            end
            if (!was_busy && fetch_req && !flush) begin
                diff = fetch_pc - cache_base;
                off = int'(diff);
                m_busy = 1; m_el = 0; m_c = fast_mode ? 5 : 6; m_bank = prog_bank;
                if (off < 512) begin
                    m_line = off / 16; m_nib = off % 16;
                    if (mvalid[m_line]) begin m_kind = 0; m_total = fast_mode ? 1 : 2; end
                    else begin
                        m_kind = 1; m_total = 16 * m_c;
                        m_lbase = (cache_base + (diff & 16'hFFF0)) & 16'hFFF0;
                    end
                end else begin
                    m_kind = 2; m_total = m_c; m_pc = fetch_pc;
                end
            end
            if (host_wr) begin
                mcache[hidx] = host_wdata;
                if (hidx % 16 == 15) mvalid[hidx / 16] = 1;
            end
            if (fill_wr) mcache[fill_i] = fbyte;
            if (set_v) mvalid[done_line] = 1;
            if (flush) foreach (mvalid[i]) mvalid[i] = 0;
            e_hrd = nxt_hrd;
            e_req = m_busy && (m_kind != 0) && ((m_el + 1) % m_c == 0);
            if (e_req) begin
                e_addr = {m_bank, (m_kind == 1) ? (m_lbase + 16'(m_el / m_c)) : m_pc};
                e_ram = (m_bank > 8'h5F);
            end
        end
    end

    task automatic cmp(input string what, input logic [23:0] got, input logic [23:0] exp);
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        vectors++;
        cmp("R10 fetch_done", 24'(fetch_done), 24'(e_done));
        cmp("R2/R3/R4 fetch_data", 24'(fetch_data), 24'(e_data));
        cmp("R3/R4 mem_req", 24'(mem_req), 24'(e_req));
        if (e_req) begin
            cmp("R3/R4 mem_addr", mem_addr, e_addr);
            cmp("R5 mem_ram", 24'(mem_ram), 24'(e_ram));
        end
        cmp("R8 host_rdata", 24'(host_rdata), 24'(e_hrd));
    end

    task automatic do_fetch(input logic [15:0] pc);
        fetch_pc = pc; fetch_req = 1;
        @(negedge clk);
        while (!fetch_done) @(negedge clk);
        fetch_req = 0;
    endtask

    task automatic hwrite(input logic [15:0] a, input logic [7:0] d);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic hread(input logic [15:0] a);
        host_rd = 1; host_addr = a;
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst_n = 0; cache_base = 0; prog_bank = 0; fast_mode = 0; flush = 0;
        fetch_req = 0; fetch_pc = 0; host_rd = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cache_base = 16'h1000; prog_bank = 8'h01;
        tag = "R1 R3 slow fill";       do_fetch(16'h1003);
        tag = "R2 slow hit";           do_fetch(16'h100C);
        tag = "R1 R4 below base";      do_fetch(16'h0FFF);
        tag = "R1 R3 last line";       do_fetch(16'h11FF);
        tag = "R1 R4 offset 512";      do_fetch(16'h1200);
        fast_mode = 1;
        tag = "R11 R2 fast hit";       do_fetch(16'h1001);
        tag = "R11 R3 fast fill";      do_fetch(16'h1025);
        prog_bank = 8'h60;
        tag = "R5 R4 ram direct";      do_fetch(16'h2000);
        tag = "R5 R3 ram fill";        do_fetch(16'h1047);
        prog_bank = 8'h5F;
        tag = "R5 R4 rom top bank";    do_fetch(16'h3000);
        fast_mode = 0; prog_bank = 8'h01;
        // R6: flush, then a former hit misses
        tag = "R6 flush idle"; flush = 1; @(negedge clk); flush = 0;
        do_fetch(16'h100C);
        // R6: a request raised together with flush waits one cycle
        tag = "R6 flush blocks accept";
        fetch_pc = 16'h1030; fetch_req = 1; flush = 1;
        @(negedge clk); flush = 0;
        while (!fetch_done) @(negedge clk);
        fetch_req = 0;
        // R7: abort a fill, held request restarts it
        tag = "R7 flush aborts fill";
        fork
            do_fetch(16'h1100);
            begin repeat (30) @(negedge clk); flush = 1; @(negedge clk); flush = 0; end
        join
        tag = "R7 restarted line hits"; do_fetch(16'h1105);
        // R1 R3: base near top of the space, fill source wraps
        cache_base = 16'hFF00;
        tag = "R1 R3 wrapped window";  do_fetch(16'h0010);
        tag = "R2 wrapped hit";        do_fetch(16'h0011);
        // R8: host reads of the filled line (index 0x110)
        tag = "R8 host read";
        for (int i = 0; i < 16; i++) hread(16'h0210 + 16'(i));
        repeat (2) @(negedge clk);
        // R9: full line written by host becomes valid (index 0x50..0x5F)
        tag = "R9 host full line";
        for (int i = 0; i < 16; i++) hwrite(16'h0150 + 16'(i), 8'hC0 + 8'(i));
        do_fetch(16'hFF53);
        // R9: last byte missing, line stays invalid (index 0x60..0x6E)
        tag = "R9 host partial line";
        for (int i = 0; i < 15; i++) hwrite(16'h0160 + 16'(i), 8'h90 + 8'(i));
        do_fetch(16'hFF62);
        // R8 R9: host traffic during a fill of line 8
        tag = "R8 R9 host during fill";
        fork
            do_fetch(16'hFF80);
            begin
                repeat (10) @(negedge clk); hwrite(16'h0185, 8'h77);
                hread(16'h0185); hwrite(16'h01A0, 8'h33); hread(16'h01A0);
            end
        join
        tag = "R8 host readback"; hread(16'h0185); hread(16'h0180);
        // R6 R9: flush wins over last-byte validation
        tag = "R6 R9 flush beats host";
        for (int i = 0; i < 15; i++) hwrite(16'h0190 + 16'(i), 8'h40 + 8'(i));
        flush = 1; hwrite(16'h019F, 8'h4F); flush = 0;
        do_fetch(16'hFF94);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule